// File: doc/BRIEF.md
# Widening Horizontal Add/Subtract Unit

This block takes one 128-bit vector, splits it into packed elements and reduces neighbouring elements into wider output lanes. A group of adjacent elements (two, four or eight bytes; two or four words; or two doublewords) collapses into one output lane whose width equals the group's total width. Every element is widened before any arithmetic, so no result can overflow.

A 4-bit mode code picks the element width, the group size, and whether elements are sign-extended or zero-extended. Three further codes select signed pairwise differences, where each even element has the odd element above it subtracted from it. The one unused code yields a zero vector. Element 0 always occupies the least significant bits, both at the input and at the output.

Inputs arrive with `in_valid`. The result is registered once and appears with `out_valid` on the next cycle. The block has no back-pressure: the consumer must accept every result in the cycle it is presented, and a new operand may be issued on every cycle.

Top module: `hadd_widen_unit`

## Requirements
- R1: Codes 0 (signed) and 1 (unsigned) sum byte pairs into 8 words, with output word i at bits [16i+15:16i] equal to byte 2i plus byte 2i+1.
- R2: Codes 2/3 (signed/unsigned) sum four consecutive bytes into 4 doublewords, and codes 4/5 sum eight consecutive bytes into 2 quadwords.
- R3: Codes 6/7 (signed/unsigned) sum word pairs into 4 doublewords, and codes 8/9 sum four consecutive words into 2 quadwords.
- R4: Codes 10/11 (signed/unsigned) sum doubleword pairs into 2 quadwords.
- R5: Even add codes sign-extend each source element and odd add codes zero-extend it to the output lane width, so every result is exact with no wrap.
- R6: Code 12 (bytes to words), 13 (words to doublewords) and 14 (doublewords to quadwords) give signed r[i] = a[2i] - a[2i+1] with sign extension.
- R7: Code 15 produces an all-zero output vector.
- R8: `out_valid` equals `in_valid` delayed by one clock, and `out_vec` carries the result of the operand presented on that earlier cycle.
- R9: While `in_valid` is low, `out_vec` holds its previous value.
- R10: While reset is high, `out_valid` and `out_vec` are driven to zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand and mode are valid this cycle |
| in_mode | input | 4 | Operation code (see R1 to R7) |
| in_vec | input | 128 | Source vector, element 0 in low bits |
| out_valid | output | 1 | Result is valid this cycle |
| out_vec | output | 128 | Widened result vector |

## Verification
The checker watches on every cycle the one-cycle relation between `in_valid` and `out_valid`, the holding of the result when no operand arrives, the zero result of the unused code, the reset state, and the lowest lane of the unsigned byte-pair sum and of the doubleword difference. The bench's vector table covers every code, with operands at the signed and unsigned extremes and with distinct values in each position. This shows that the grouping, lane ordering and sign handling are correct in all lanes, which the per-cycle properties do not cover.

// File: rtl/hadd_pkg.sv
package hadd_pkg;

  localparam int NSHAPE = 6;

  typedef enum logic [3:0] {
    MODE_S_B2W = 4'd0,  MODE_U_B2W = 4'd1,
    MODE_S_B4D = 4'd2,  MODE_U_B4D = 4'd3,
    MODE_S_B8Q = 4'd4,  MODE_U_B8Q = 4'd5,
    MODE_S_W2D = 4'd6,  MODE_U_W2D = 4'd7,
    MODE_S_W4Q = 4'd8,  MODE_U_W4Q = 4'd9,
    MODE_S_D2Q = 4'd10, MODE_U_D2Q = 4'd11,
    MODE_DIF_B = 4'd12, MODE_DIF_W = 4'd13,
    MODE_DIF_D = 4'd14, MODE_NONE  = 4'd15
  } hadd_mode_e;

  typedef struct packed {
    logic [2:0] shape;  // index of the reduction shape
    logic       sgn;    // sign-extend elements
    logic       sub;    // odd elements are subtracted
    logic       legal;  // code is defined
  } hadd_ctl_t;

  // element width of each shape
  function automatic int shape_src_w(int g);
    case (g)
      0, 1, 2: return 8;
      3, 4:    return 16;
      default: return 32;
    endcase
  endfunction

  // number of elements folded into one output lane
  function automatic int shape_grp(int g);
    case (g)
      1:       return 4;
      2:       return 8;
      4:       return 4;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/hadd_mode_decode.sv
module hadd_mode_decode
  import hadd_pkg::*;
(
  input  logic [3:0] mode,
  output hadd_ctl_t  ctl
);

  always_comb begin
    ctl = '0;
    if (mode < 4'd12) begin
      ctl.shape = mode[3:1];
      ctl.sgn   = ~mode[0];
      ctl.legal = 1'b1;
    end else begin
      case (hadd_mode_e'(mode))
        MODE_DIF_B: begin ctl.shape = 3'd0; ctl.sgn = 1'b1; ctl.sub = 1'b1; ctl.legal = 1'b1; end
        MODE_DIF_W: begin ctl.shape = 3'd3; ctl.sgn = 1'b1; ctl.sub = 1'b1; ctl.legal = 1'b1; end
        MODE_DIF_D: begin ctl.shape = 3'd5; ctl.sgn = 1'b1; ctl.sub = 1'b1; ctl.legal = 1'b1; end
        default:    ctl = '0;
      endcase
    end
  end

endmodule

// File: rtl/hadd_group_sum.sv
module hadd_group_sum #(
  parameter int VEC_W = 128,
  parameter int SRC_W = 8,
  parameter int GRP   = 2
) (
  input  logic [VEC_W-1:0] src,
  input  logic             sgn,
  input  logic             sub,
  output logic [VEC_W-1:0] dst
);

  localparam int DST_W = SRC_W * GRP;
  localparam int N_OUT = VEC_W / DST_W;
  localparam int EXT_W = DST_W - SRC_W;

  for (genvar j = 0; j < N_OUT; j++) begin : g_lane
    logic [DST_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int k = 0; k < GRP; k++) begin
        logic [SRC_W-1:0] el;
        logic [DST_W-1:0] wide;
        el   = src[(j*GRP + k)*SRC_W +: SRC_W];
        wide = {{EXT_W{sgn & el[SRC_W-1]}}, el};
        if (sub && (k % 2 == 1)) acc = acc - wide;
        else                     acc = acc + wide;
      end
    end
    assign dst[j*DST_W +: DST_W] = acc;
  end

endmodule

// File: rtl/hadd_widen_unit.sv
module hadd_widen_unit
  import hadd_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3:0]       in_mode,
  input  logic [VEC_W-1:0] in_vec,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vec
);

  hadd_ctl_t        ctl;
  logic [VEC_W-1:0] sums [NSHAPE];
  logic [VEC_W-1:0] result;

  hadd_mode_decode u_dec (
    .mode (in_mode),
    .ctl  (ctl)
  );

  for (genvar g = 0; g < NSHAPE; g++) begin : g_shape
    hadd_group_sum #(
      .VEC_W (VEC_W),
      .SRC_W (shape_src_w(g)),
      .GRP   (shape_grp(g))
    ) u_sum (
      .src (in_vec),
      .sgn (ctl.sgn),
      .sub (ctl.sub),
      .dst (sums[g])
    );
  end

  always_comb begin
    result = '0;
    for (int g = 0; g < NSHAPE; g++) begin
      if (ctl.legal && (ctl.shape == 3'(g))) result = sums[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_vec <= result;
    end
  end

endmodule

// File: rtl/hadd_widen_unit_chk.sv
module hadd_widen_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [3:0]       in_mode,
  input logic [VEC_W-1:0] in_vec,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_vec
);

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_follows_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_vec));

  assert_unused_code_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 4'd15) |=> (out_vec == '0));

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (!out_valid && out_vec == '0));

  assert_unsigned_pair_lane0_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 4'd1) |=>
      (out_vec[15:0] == ({8'h00, $past(in_vec[7:0])} + {8'h00, $past(in_vec[15:8])})));

  assert_dword_diff_lane0_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 4'd14) |=>
      (out_vec[63:0] == ({{32{$past(in_vec[31])}}, $past(in_vec[31:0])}
                       - {{32{$past(in_vec[63])}}, $past(in_vec[63:32])})));

endmodule

bind hadd_widen_unit hadd_widen_unit_chk #(.VEC_W(VEC_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_mode   (in_mode),
  .in_vec    (in_vec),
  .out_valid (out_valid),
  .out_vec   (out_vec)
);

// File: tb/hadd_widen_unit_tb_top.sv
module hadd_widen_unit_tb_top;

  localparam int VEC_W = 128;

  typedef struct packed {
    logic [3:0]       mode;
    logic [VEC_W-1:0] a;
    logic [VEC_W-1:0] e;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    // R1 R5 signed byte pairs of -1
    '{4'd0,  {16{8'hFF}}, {8{16'hFFFE}}},
    // R1 R5 unsigned byte pairs of 255
    '{4'd1,  {16{8'hFF}}, {8{16'h01FE}}},
    // R2 byte quads
    '{4'd2,  {16{8'hFF}}, {4{32'hFFFF_FFFC}}},
    '{4'd3,  {16{8'hFF}}, {4{32'h0000_03FC}}},
    // R2 byte octets
    '{4'd4,  {16{8'hFF}}, {2{64'hFFFF_FFFF_FFFF_FFF8}}},
    '{4'd5,  {16{8'hFF}}, {2{64'h0000_0000_0000_07F8}}},
    // R3 word pairs
    '{4'd6,  {16{8'hFF}}, {4{32'hFFFF_FFFE}}},
    '{4'd7,  {16{8'hFF}}, {4{32'h0001_FFFE}}},
    // R3 word quads
    '{4'd8,  {16{8'hFF}}, {2{64'hFFFF_FFFF_FFFF_FFFC}}},
    '{4'd9,  {16{8'hFF}}, {2{64'h0000_0000_0003_FFFC}}},
    // R4 doubleword pairs
    '{4'd10, {16{8'hFF}}, {2{64'hFFFF_FFFF_FFFF_FFFE}}},
    '{4'd11, {16{8'hFF}}, {2{64'h0000_0001_FFFF_FFFE}}},
    // R6 extreme differences: -128-127, -32768-32767, -2^31-(2^31-1)
    '{4'd12, {8{16'h7F80}}, {8{16'hFF01}}},
    '{4'd13, {4{32'h7FFF_8000}}, {4{32'hFFFF_0001}}},
    '{4'd14, {2{64'h7FFF_FFFF_8000_0000}}, {2{64'hFFFF_FFFF_0000_0001}}},
    // R7 unused code
    '{4'd15, {16{8'hFF}}, 128'h0},
    // R1 lane ordering, byte i = i
    '{4'd1,  128'h0F0E0D0C_0B0A0908_07060504_03020100, 128'h001D0019_00150011_000D0009_00050001},
    // R2 octet ordering
    '{4'd5,  128'h0F0E0D0C_0B0A0908_07060504_03020100, 128'h00000000_0000005C_00000000_0000001C},
    // R6 ordering: each pair gives -1
    '{4'd12, 128'h0F0E0D0C_0B0A0908_07060504_03020100, {8{16'hFFFF}}},
    // R5 mixed signs 127 + (-128) under signed code
    '{4'd0,  {8{16'h807F}}, {8{16'hFFFF}}}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [3:0]       in_mode = '0;
  logic [VEC_W-1:0] in_vec = '0;
  logic             out_valid;
  logic [VEC_W-1:0] out_vec;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  hadd_widen_unit #(.VEC_W(VEC_W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_vec   (out_vec)
  );

  task automatic check(string req, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 out_valid", {127'b0, out_valid}, '0);
    check("R10 out_vec", out_vec, '0);
    rst = 1'b0;

    // streamed table, one operand per cycle
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_mode  = TBL[i].mode;
      in_vec   = TBL[i].a;
      @(negedge clk);
      check($sformatf("R8 valid v%0d", i), {127'b0, out_valid}, {127'b0, 1'b1});
      check($sformatf("table v%0d mode %0d", i, TBL[i].mode), out_vec, TBL[i].e);
    end

    // R9 hold while idle, R8 valid drops
    in_valid = 1'b0;
    in_mode  = 4'd1;
    in_vec   = {16{8'h11}};
    @(negedge clk);
    check("R8 idle", {127'b0, out_valid}, '0);
    check("R9 hold", out_vec, TBL[NV-1].e);
    @(negedge clk);
    check("R9 hold second cycle", out_vec, TBL[NV-1].e);

    // R5 unsigned word pair at the top element values
    in_valid = 1'b1;
    in_mode  = 4'd7;
    in_vec   = {4{32'hFFFF_0001}};
    @(negedge clk);
    check("R5 unsigned words", out_vec, {4{32'h0001_0000}});

    // R10 reset mid-stream
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid-stream valid", {127'b0, out_valid}, '0);
    check("R10 mid-stream vec", out_vec, '0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule